// File: doc/BRIEF.md
# Page Access Permission Checker

This block judges one memory access against the flag bits of a page-table entry and the processor's current protection controls. Each request gives the page's present, writable, user-accessible and no-execute bits, the access kind (data read, data write or instruction fetch) and the current privilege level. The result is registered and appears one cycle later: either the access is allowed, or a page fault is raised with a reason code that names the first rule that failed.

The usual check keeps user-level code out of pages reserved for the supervisor. Three further rules apply on top of it. The first stops the most privileged level from fetching instructions out of user pages. The second stops the most privileged level from making data accesses to user pages unless an override flag is set. The third blocks instruction fetches from no-execute pages. The override flag lives inside the block. A set command and a clear command change it, so supervisor code can open a short window of access to user memory and then close it again.

Top module: `page_perm_checker`

## Requirements
- R1: A request strobed on `req_valid` gets its result one clock later on `rsp_valid`, with exactly one of `rsp_ok` and `rsp_fault` high. In a cycle with no response all three are low and `rsp_reason` is 0. Access kind encoding: 00 read, 01 write, 10 fetch, 11 treated as a read.
- R2: A page with present = 0 always faults with reason 1, whatever the other inputs are.
- R3: A present page with user = 0, accessed at level 3, faults with reason 2 for every access kind.
- R4: A present page with user = 1 is allowed at every level (0 to 3) when no other rule blocks it.
- R5: With `smep_en` = 1, a fetch at level 0 from a user page faults with reason 3. With `smep_en` = 0 the same fetch is not blocked by this rule.
- R6: With `smap_en` = 1 and the override flag clear, a read or write at level 0 to a user page faults with reason 4. With the flag set, or with `smap_en` = 0, this rule does not fire.
- R7: The override flag is 0 after reset. `ovr_set` sets it and `ovr_clr` clears it, and clear wins when both are high. The flag changes at the clock edge, so a request in the same cycle as a command is judged with the flag value from before the command.
- R8: A write to a page with writable = 0 faults with reason 5 at level 3. At levels 0 to 2 such a write is not blocked by this rule.
- R9: With `nx_en` = 1, a fetch from a page with no-execute = 1 faults with reason 6. The no-execute bit has no effect on reads and writes, or when `nx_en` = 0.
- R10: When several rules fail at once, the reported reason is the first in this order: not-present (1), privilege (2), supervisor fetch (3), supervisor data (4), write (5), no-execute (6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| pte_present | input | 1 | Page present bit |
| pte_writable | input | 1 | Page writable bit |
| pte_user | input | 1 | Page user-accessible bit |
| pte_noexec | input | 1 | Page no-execute bit |
| acc_kind | input | 2 | Access kind (00 read, 01 write, 10 fetch, 11 read) |
| cur_level | input | 2 | Current privilege level, 0 most privileged |
| smep_en | input | 1 | Supervisor fetch protection enable |
| smap_en | input | 1 | Supervisor data protection enable |
| nx_en | input | 1 | No-execute enforcement enable |
| ovr_set | input | 1 | Set the override flag |
| ovr_clr | input | 1 | Clear the override flag |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_ok | output | 1 | Access allowed |
| rsp_fault | output | 1 | Page fault raised |
| rsp_reason | output | 3 | Fault reason code, 0 when allowed |

## Verification
The assertions check these things on every cycle: the one-cycle response timing, that allowed and faulted are never both reported, that a missing page always gives reason 1, and that the privilege and supervisor-fetch rules give their codes. The override flag cannot be seen at the ports, so its effect is only visible through the bench's scenarios. Those scenarios cover set and clear commands, both commands at once, and requests in the same cycle as a command. An exhaustive sweep over every combination of page bits, access kind, level, enables and flag commands shows the full priority order.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  localparam int RSN_W     = 3;
  localparam int NUM_RULES = 6;

  typedef enum logic [RSN_W-1:0] {
    RSN_NONE        = 3'd0,
    RSN_NOT_PRESENT = 3'd1,
    RSN_PRIV        = 3'd2,
    RSN_SUP_EXEC    = 3'd3,
    RSN_SUP_DATA    = 3'd4,
    RSN_WRITE       = 3'd5,
    RSN_NOEXEC      = 3'd6
  } rsn_e;

  typedef struct packed {
    logic present;
    logic writable;
    logic user;
    logic noexec;
  } pte_flags_t;

endpackage

// File: rtl/pgchk_ovr_flag.sv
module pgchk_ovr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = clr_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pgchk_rules.sv
module pgchk_rules
  import pgchk_pkg::*;
#(
  parameter int LEVEL_W = 2
) (
  input  pte_flags_t            pte_i,
  input  acc_e                  acc_i,
  input  logic [LEVEL_W-1:0]    level_i,
  input  logic                  smep_en_i,
  input  logic                  smap_en_i,
  input  logic                  nx_en_i,
  input  logic                  ovr_i,
  output logic [NUM_RULES-1:0]  hit_o
);
  localparam logic [LEVEL_W-1:0] USER_LVL = {LEVEL_W{1'b1}};
  localparam logic [LEVEL_W-1:0] TOP_LVL  = '0;

  logic is_fetch;
  logic is_write;
  logic at_user;
  logic at_top;

  always_comb begin
    is_fetch = (acc_i == ACC_FETCH);
    is_write = (acc_i == ACC_WRITE);
    at_user  = (level_i == USER_LVL);
    at_top   = (level_i == TOP_LVL);

    // index 0 is the highest priority rule
    hit_o[0] = ~pte_i.present;
    hit_o[1] = at_user & ~pte_i.user;
    hit_o[2] = smep_en_i & at_top & pte_i.user & is_fetch;
    hit_o[3] = smap_en_i & at_top & pte_i.user & ~is_fetch & ~ovr_i;
    hit_o[4] = is_write & at_user & ~pte_i.writable;
    hit_o[5] = nx_en_i & is_fetch & pte_i.noexec;
  end
endmodule

// File: rtl/pgchk_prio.sv
module pgchk_prio #(
  parameter int N = 6,
  parameter int W = 3
) (
  input  logic [N-1:0] hit_i,
  output logic         any_o,
  output logic [W-1:0] code_o
);
  always_comb begin
    any_o  = |hit_i;
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        code_o = W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/page_perm_checker.sv
module page_perm_checker
  import pgchk_pkg::*;
#(
  parameter int LEVEL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               pte_present,
  input  logic               pte_writable,
  input  logic               pte_user,
  input  logic               pte_noexec,
  input  logic [1:0]         acc_kind,
  input  logic [LEVEL_W-1:0] cur_level,
  input  logic               smep_en,
  input  logic               smap_en,
  input  logic               nx_en,
  input  logic               ovr_set,
  input  logic               ovr_clr,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic               rsp_fault,
  output logic [RSN_W-1:0]   rsp_reason
);
  pte_flags_t           pte;
  logic                 ovr_flag;
  logic [NUM_RULES-1:0] rule_hit;
  logic                 any_fault;
  logic [RSN_W-1:0]     fault_code;

  logic             vld_d, vld_q;
  logic             ok_d, ok_q;
  logic             flt_d, flt_q;
  logic [RSN_W-1:0] rsn_d, rsn_q;

  assign pte = '{present: pte_present, writable: pte_writable,
                 user: pte_user, noexec: pte_noexec};

  pgchk_ovr_flag i_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ovr_set),
    .clr_i  (ovr_clr),
    .flag_o (ovr_flag)
  );

  pgchk_rules #(.LEVEL_W(LEVEL_W)) i_rules (
    .pte_i     (pte),
    .acc_i     (acc_e'(acc_kind)),
    .level_i   (cur_level),
    .smep_en_i (smep_en),
    .smap_en_i (smap_en),
    .nx_en_i   (nx_en),
    .ovr_i     (ovr_flag),
    .hit_o     (rule_hit)
  );

  pgchk_prio #(.N(NUM_RULES), .W(RSN_W)) i_prio (
    .hit_i  (rule_hit),
    .any_o  (any_fault),
    .code_o (fault_code)
  );

  always_comb begin
    vld_d = req_valid;
    ok_d  = req_valid & ~any_fault;
    flt_d = req_valid & any_fault;
    rsn_d = req_valid ? fault_code : RSN_W'(RSN_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
      flt_q <= 1'b0;
      rsn_q <= '0;
    end else begin
      vld_q <= vld_d;
      ok_q  <= ok_d;
      flt_q <= flt_d;
      rsn_q <= rsn_d;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_ok     = ok_q;
  assign rsp_fault  = flt_q;
  assign rsp_reason = rsn_q;
endmodule

// File: rtl/page_perm_checker_sva.sv
module page_perm_checker_sva
  import pgchk_pkg::*;
#(
  parameter int LEVEL_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               pte_present,
  input logic               pte_user,
  input logic [1:0]         acc_kind,
  input logic [LEVEL_W-1:0] cur_level,
  input logic               smep_en,
  input logic               rsp_valid,
  input logic               rsp_ok,
  input logic               rsp_fault,
  input logic [RSN_W-1:0]   rsp_reason
);
  localparam logic [LEVEL_W-1:0] USER_LVL = {LEVEL_W{1'b1}};

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_req_no_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_ok && !rsp_fault));

  p_one_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ok != rsp_fault));

  p_ok_no_reason_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (rsp_reason == RSN_W'(RSN_NONE)));

  p_not_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pte_present) |=>
      (rsp_fault && rsp_reason == RSN_W'(RSN_NOT_PRESENT)));

  p_user_priv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pte_present && !pte_user && cur_level == USER_LVL) |=>
      (rsp_fault && rsp_reason == RSN_W'(RSN_PRIV)));

  p_sup_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pte_present && pte_user && cur_level == '0 && smep_en &&
     acc_kind == 2'b10) |=>
      (rsp_fault && rsp_reason == RSN_W'(RSN_SUP_EXEC)));
endmodule

bind page_perm_checker page_perm_checker_sva #(.LEVEL_W(LEVEL_W)) i_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .pte_present (pte_present),
  .pte_user    (pte_user),
  .acc_kind    (acc_kind),
  .cur_level   (cur_level),
  .smep_en     (smep_en),
  .rsp_valid   (rsp_valid),
  .rsp_ok      (rsp_ok),
  .rsp_fault   (rsp_fault),
  .rsp_reason  (rsp_reason)
);

// File: tb/test_page_perm_checker.sv
`timescale 1ns/1ps
module test_page_perm_checker;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       pte_present, pte_writable, pte_user, pte_noexec;
  logic [1:0] acc_kind;
  logic [1:0] cur_level;
  logic       smep_en, smap_en, nx_en;
  logic       ovr_set, ovr_clr;
  logic       rsp_valid, rsp_ok, rsp_fault;
  logic [2:0] rsp_reason;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_tag  = "R1";
  bit    mflag;
  bit    exp_vld, exp_ok, exp_flt;
  int    exp_rsn;
  bit    done = 0;

  page_perm_checker i_page_perm_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .pte_present(pte_present), .pte_writable(pte_writable),
    .pte_user(pte_user), .pte_noexec(pte_noexec),
    .acc_kind(acc_kind), .cur_level(cur_level),
    .smep_en(smep_en), .smap_en(smap_en), .nx_en(nx_en),
    .ovr_set(ovr_set), .ovr_clr(ovr_clr),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
    .rsp_reason(rsp_reason)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference: reason for the current inputs
  function automatic int ref_reason();
    bit fetch = (acc_kind == 2'b10);
    bit write = (acc_kind == 2'b01);
    if (!pte_present) return 1;
    if (cur_level == 3 && !pte_user) return 2;
    if (smep_en && cur_level == 0 && pte_user && fetch) return 3;
    if (smap_en && cur_level == 0 && pte_user && !fetch && !mflag) return 4;
    if (write && cur_level == 3 && !pte_writable) return 5;
    if (nx_en && fetch && pte_noexec) return 6;
    return 0;
  endfunction

  task automatic check_outputs();
    n_checks++;
    if (rsp_valid !== exp_vld || rsp_ok !== exp_ok || rsp_fault !== exp_flt ||
        int'(rsp_reason) != exp_rsn) begin
      n_errors++;
      $display("FAIL %s: got vld=%0b ok=%0b flt=%0b rsn=%0d, expected vld=%0b ok=%0b flt=%0b rsn=%0d",
               cur_tag, rsp_valid, rsp_ok, rsp_fault, rsp_reason,
               exp_vld, exp_ok, exp_flt, exp_rsn);
    end
  endtask

  // called at a falling edge: check the last result, then apply new inputs
  task automatic step(input bit v, input bit p, input bit w, input bit u,
                      input bit nx, input logic [1:0] k, input logic [1:0] lv,
                      input bit se, input bit sa, input bit ne,
                      input bit st, input bit cl);
    int r;
    check_outputs();
    req_valid = v; pte_present = p; pte_writable = w; pte_user = u;
    pte_noexec = nx; acc_kind = k; cur_level = lv;
    smep_en = se; smap_en = sa; nx_en = ne; ovr_set = st; ovr_clr = cl;
    r = ref_reason();
    exp_vld = v;
    exp_ok  = v && (r == 0);
    exp_flt = v && (r != 0);
    exp_rsn = v ? r : 0;
    if (cl) mflag = 0;
    else if (st) mflag = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; pte_present = 0; pte_writable = 0; pte_user = 0;
    pte_noexec = 0; acc_kind = 0; cur_level = 0; smep_en = 0; smap_en = 0;
    nx_en = 0; ovr_set = 0; ovr_clr = 0;
    mflag = 0; exp_vld = 0; exp_ok = 0; exp_flt = 0; exp_rsn = 0;
    repeat (3) @(negedge clk);
    cur_tag = "R1 reset";
    check_outputs();
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle then a single allowed request, then idle again
    cur_tag = "R1";
    step(0,1,1,1,0,2'b00,2'd3,0,0,0,0,0);
    step(1,1,1,1,0,2'b11,2'd3,0,0,0,0,0);
    step(0,0,0,0,0,2'b00,2'd0,0,0,0,0,0);

    // R2: missing page beats everything
    cur_tag = "R2";
    step(1,0,0,0,1,2'b10,2'd3,1,1,1,0,0);
    step(1,0,1,1,0,2'b00,2'd0,0,0,0,0,0);

    // R3: supervisor page at level 3, each access kind
    cur_tag = "R3";
    for (int k = 0; k < 4; k++) step(1,1,1,0,0,2'(k),2'd3,0,0,0,0,0);

    // R4: user page from every level with protections off
    cur_tag = "R4";
    for (int l = 0; l < 4; l++) step(1,1,1,1,0,2'b00,2'(l),0,0,0,0,0);

    // R5: supervisor fetch from user page with and without enable
    cur_tag = "R5";
    step(1,1,1,1,0,2'b10,2'd0,1,0,0,0,0);
    step(1,1,1,1,0,2'b10,2'd0,0,0,0,0,0);
    step(1,1,1,1,0,2'b10,2'd1,1,0,0,0,0);

    // R6 / R7: supervisor data access and the override flag
    cur_tag = "R6";
    step(1,1,1,1,0,2'b00,2'd0,0,1,0,0,0);
    step(1,1,1,1,0,2'b01,2'd0,0,1,0,0,0);
    cur_tag = "R7 same-cycle set";
    step(1,1,1,1,0,2'b00,2'd0,0,1,0,1,0);
    cur_tag = "R7 after set";
    step(1,1,1,1,0,2'b00,2'd0,0,1,0,0,0);
    cur_tag = "R7 set and clear";
    step(1,1,1,1,0,2'b01,2'd0,0,1,0,1,1);
    cur_tag = "R7 after both";
    step(1,1,1,1,0,2'b01,2'd0,0,1,0,0,0);
    cur_tag = "R6 disabled";
    step(1,1,1,1,0,2'b00,2'd0,0,0,0,0,0);

    // R8: read-only writes by level
    cur_tag = "R8";
    for (int l = 0; l < 4; l++) step(1,1,0,1,0,2'b01,2'(l),0,0,0,0,0);

    // R9: no-execute pages
    cur_tag = "R9";
    step(1,1,1,1,1,2'b10,2'd3,0,0,1,0,0);
    step(1,1,1,1,1,2'b10,2'd3,0,0,0,0,0);
    step(1,1,1,1,1,2'b00,2'd3,0,0,1,0,0);
    step(1,1,0,1,1,2'b01,2'd2,0,0,1,0,0);

    // R10: exhaustive sweep including flag commands
    cur_tag = "R10";
    for (int i = 0; i < 16384; i++) begin
      step(1, i[0], i[1], i[2], i[3], i[5:4], i[7:6], i[8], i[9], i[10],
           i[11], i[12] & i[13]);
    end
    step(0,0,0,0,0,2'b00,2'd0,0,0,0,0,0);
    check_outputs();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule